// File: doc/BRIEF.md
# Stride Value Predictor Table

This block keeps one prediction record per static instruction, in a direct-mapped table indexed by the instruction address. Each record holds an address tag, the result the instruction last produced, the stride between its last two results, and a two-bit saturating confidence counter. A lookup presents an instruction address. One cycle later the block answers with a hit flag, the stored last value, the stored stride, the extrapolated prediction (last value plus stride) and a flag that says whether the prediction is trusted.

An update presents an instruction address and its real result. On a hit the block works out whether the earlier prediction was right and moves the counter one step up or down. It then takes the new stride as the difference between the new and old results and stores the new result. On a miss the record is taken over for the new instruction. A repair form of the update rewrites only the stored last value. It serves when a speculative update wrote a result that later proved wrong.

The raw last value and stride are returned as well as the prediction, so that a downstream unit can extrapolate several iterations ahead on its own. When a lookup and an update address the same record in the same cycle, the update is applied first and the lookup answer shows the updated contents.

Top module: `stride_value_predictor`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every record is empty, so any lookup misses until a record is written.
- R2: `rsp_valid` in a cycle equals `lk_valid` of the cycle before; the answer fields belong to that earlier request.
- R3: The record index is address bits [ALIGN_W+IDX_W-1:ALIGN_W] and the tag is the remaining upper bits; the low ALIGN_W bits are ignored. A hit needs a filled record with an equal tag. On a miss, `rsp_last`, `rsp_stride` and `rsp_pred` are 0 and `rsp_confident` is 0.
- R4: On a hit, `rsp_pred` equals `rsp_last + rsp_stride` modulo 2^VAL_W.
- R5: A normal update (`up_fix`=0) that misses fills the record with the new tag and the result, sets the stride to 0 and the counter to 0, and displaces any aliasing instruction.
- R6: A normal update that hits sets the stride to the result minus the old last value (modulo 2^VAL_W) and the last value to the result.
- R7: On a normal hitting update, the counter rises by one, saturating at 3, when the result equals the old last value plus the old stride; otherwise it falls by one, saturating at 0.
- R8: `rsp_confident` is 1 exactly when the lookup hits and the record's counter is 2 or 3.
- R9: When a lookup and an update select the same record in one cycle, the answer shows the contents after that update.
- R10: A repair update (`up_fix`=1) that hits replaces only the last value and leaves the stride and counter unchanged. A repair that misses changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup instruction address |
| up_valid | input | 1 | Update request |
| up_pc | input | PC_W | Update instruction address |
| up_value | input | VAL_W | Actual result, or corrected result on repair |
| up_fix | input | 1 | 1: repair update (last value only) |
| rsp_valid | output | 1 | Answer valid (one cycle after lookup) |
| rsp_hit | output | 1 | Record matched the looked-up address |
| rsp_last | output | VAL_W | Stored last value |
| rsp_stride | output | VAL_W | Stored stride |
| rsp_pred | output | VAL_W | Last value plus stride |
| rsp_confident | output | 1 | Counter is at least 2 |

## Verification
The bench builds the block with a 16-bit address, two alignment bits, only four records and 16-bit values. Four records make index aliasing and record displacement happen within a few addresses. They also make collisions between a lookup and an update in the same cycle frequent during the random phase. The narrow values let strides that go negative and sums that wrap past 2^16 occur with small constants, so the modular arithmetic of the stride and the prediction is covered.

// File: rtl/svp_pkg.sv
// Shared types and helpers for the stride value predictor.
// Assumes a two-bit confidence counter; the threshold and ceiling are fixed here.
package svp_pkg;
    typedef logic [1:0] conf_t;

    localparam conf_t CONF_MAX  = 2'd3;
    localparam conf_t CONF_ZERO = 2'd0;
    localparam conf_t CONF_USE  = 2'd2;

    // Saturating counter step: up on a correct prediction, down otherwise.
    function automatic conf_t conf_step(conf_t c, logic correct);
        conf_t r;
        if (correct) r = (c == CONF_MAX)  ? c : c + 2'd1;
        else         r = (c == CONF_ZERO) ? c : c - 2'd1;
        return r;
    endfunction

    // A counter value that allows the prediction to be used.
    function automatic logic conf_trusted(conf_t c);
        return c >= CONF_USE;
    endfunction
endpackage

// File: rtl/svp_pc_split.sv
// Splits an instruction address into a table index and a tag.
// Assumes PC_W > ALIGN_W + IDX_W; the alignment bits are dropped.
module svp_pc_split #(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6,
    localparam int TAG_W  = PC_W - ALIGN_W - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    // Index sits just above the alignment bits, the tag takes the rest.
    assign idx = pc[ALIGN_W +: IDX_W];
    assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/svp_entry_update.sv
// Computes the next contents of one record from its current contents and an update.
// Purely combinational; assumes the caller writes the result back only when an
// update is actually presented.
module svp_entry_update
    import svp_pkg::*;
#(
    parameter int TAG_W = 24,
    parameter int VAL_W = 32
) (
    input  logic             cur_valid,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic [VAL_W-1:0] cur_last,
    input  logic [VAL_W-1:0] cur_stride,
    input  conf_t            cur_conf,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [VAL_W-1:0] req_value,
    input  logic             req_fix,
    output logic             hit,
    output logic             nxt_valid,
    output logic [TAG_W-1:0] nxt_tag,
    output logic [VAL_W-1:0] nxt_last,
    output logic [VAL_W-1:0] nxt_stride,
    output conf_t            nxt_conf
);
    logic [VAL_W-1:0] old_pred;
    logic             was_right;

    // Old prediction and whether the new result matched it.
    always_comb begin
        hit       = cur_valid && (cur_tag == req_tag);
        old_pred  = cur_last + cur_stride;
        was_right = (req_value == old_pred);
    end

    // Next record: repair, train on hit, or take over on miss.
    always_comb begin
        nxt_valid  = cur_valid;
        nxt_tag    = cur_tag;
        nxt_last   = cur_last;
        nxt_stride = cur_stride;
        nxt_conf   = cur_conf;
        if (req_fix) begin
            if (hit) nxt_last = req_value;
        end else if (hit) begin
            nxt_last   = req_value;
            nxt_stride = req_value - cur_last;
            nxt_conf   = conf_step(cur_conf, was_right);
        end else begin
            nxt_valid  = 1'b1;
            nxt_tag    = req_tag;
            nxt_last   = req_value;
            nxt_stride = '0;
            nxt_conf   = CONF_ZERO;
        end
    end
endmodule

// File: rtl/svp_store.sv
// Record storage: one write port, two asynchronous read ports.
// Synchronous active-low reset empties every record. Assumes DEPTH stays small
// enough to be held in flops.
module svp_store
    import svp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 24,
    parameter int VAL_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [VAL_W-1:0] wr_last,
    input  logic [VAL_W-1:0] wr_stride,
    input  conf_t            wr_conf,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    output logic [VAL_W-1:0] ra_last,
    output logic [VAL_W-1:0] ra_stride,
    output conf_t            ra_conf,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    output logic [VAL_W-1:0] rb_last,
    output logic [VAL_W-1:0] rb_stride,
    output conf_t            rb_conf
);
    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q    [DEPTH];
    logic [VAL_W-1:0] last_q   [DEPTH];
    logic [VAL_W-1:0] stride_q [DEPTH];
    conf_t            conf_q   [DEPTH];

    // One register slice per record; reset clears it, a write replaces it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rec
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g]  <= 1'b0;
                tag_q[g]    <= '0;
                last_q[g]   <= '0;
                stride_q[g] <= '0;
                conf_q[g]   <= CONF_ZERO;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g]  <= wr_valid;
                tag_q[g]    <= wr_tag;
                last_q[g]   <= wr_last;
                stride_q[g] <= wr_stride;
                conf_q[g]   <= wr_conf;
            end
        end
    end

    // Two independent read ports.
    always_comb begin
        ra_valid  = valid_q[ra_idx];
        ra_tag    = tag_q[ra_idx];
        ra_last   = last_q[ra_idx];
        ra_stride = stride_q[ra_idx];
        ra_conf   = conf_q[ra_idx];
        rb_valid  = valid_q[rb_idx];
        rb_tag    = tag_q[rb_idx];
        rb_last   = last_q[rb_idx];
        rb_stride = stride_q[rb_idx];
        rb_conf   = conf_q[rb_idx];
    end

    // R7: a stored counter never leaves its two-bit range or moves by more than one per write
    conf_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_valid && valid_q[wr_idx] && (wr_tag == tag_q[wr_idx])
        |=> (conf_q[$past(wr_idx)] - $past(conf_q[wr_idx]) == 2'd1) ||
            ($past(conf_q[wr_idx]) - conf_q[$past(wr_idx)] == 2'd1) ||
            (conf_q[$past(wr_idx)] == $past(conf_q[wr_idx])));
endmodule

// File: rtl/stride_value_predictor.sv
// Direct-mapped stride value predictor with a confidence counter per record.
// Lookup answers are registered (one cycle latency). An update in the same cycle
// to the same record is visible in the answer. Synchronous active-low reset.
module stride_value_predictor
    import svp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6,
    parameter int VAL_W   = 32,
    localparam int TAG_W  = PC_W - ALIGN_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic             up_valid,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [VAL_W-1:0] up_value,
    input  logic             up_fix,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [VAL_W-1:0] rsp_last,
    output logic [VAL_W-1:0] rsp_stride,
    output logic [VAL_W-1:0] rsp_pred,
    output logic             rsp_confident
);
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;

    logic             lc_valid, uc_valid;
    logic [TAG_W-1:0] lc_tag, uc_tag;
    logic [VAL_W-1:0] lc_last, lc_stride, uc_last, uc_stride;
    conf_t            lc_conf, uc_conf;

    logic             un_valid, up_hit;
    logic [TAG_W-1:0] un_tag;
    logic [VAL_W-1:0] un_last, un_stride;
    conf_t            un_conf;

    logic             sel_fwd, sel_valid, sel_hit;
    logic [TAG_W-1:0] sel_tag;
    logic [VAL_W-1:0] sel_last, sel_stride;
    conf_t            sel_conf;

    svp_pc_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_lk_split (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

    svp_pc_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_up_split (
        .pc(up_pc), .idx(up_idx), .tag(up_tag));

    svp_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .VAL_W(VAL_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(up_valid), .wr_idx(up_idx),
        .wr_valid(un_valid), .wr_tag(un_tag), .wr_last(un_last),
        .wr_stride(un_stride), .wr_conf(un_conf),
        .ra_idx(lk_idx), .ra_valid(lc_valid), .ra_tag(lc_tag),
        .ra_last(lc_last), .ra_stride(lc_stride), .ra_conf(lc_conf),
        .rb_idx(up_idx), .rb_valid(uc_valid), .rb_tag(uc_tag),
        .rb_last(uc_last), .rb_stride(uc_stride), .rb_conf(uc_conf));

    svp_entry_update #(.TAG_W(TAG_W), .VAL_W(VAL_W)) u_upd (
        .cur_valid(uc_valid), .cur_tag(uc_tag), .cur_last(uc_last),
        .cur_stride(uc_stride), .cur_conf(uc_conf),
        .req_tag(up_tag), .req_value(up_value), .req_fix(up_fix),
        .hit(up_hit), .nxt_valid(un_valid), .nxt_tag(un_tag),
        .nxt_last(un_last), .nxt_stride(un_stride), .nxt_conf(un_conf));

    // Forward the post-update record when both ports select the same index.
    always_comb begin
        sel_fwd    = up_valid && (up_idx == lk_idx);
        sel_valid  = sel_fwd ? un_valid  : lc_valid;
        sel_tag    = sel_fwd ? un_tag    : lc_tag;
        sel_last   = sel_fwd ? un_last   : lc_last;
        sel_stride = sel_fwd ? un_stride : lc_stride;
        sel_conf   = sel_fwd ? un_conf   : lc_conf;
        sel_hit    = sel_valid && (sel_tag == lk_tag);
    end

    // Register the lookup answer; a miss answers with zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_last      <= '0;
            rsp_stride    <= '0;
            rsp_pred      <= '0;
            rsp_confident <= 1'b0;
        end else begin
            rsp_valid     <= lk_valid;
            rsp_hit       <= lk_valid && sel_hit;
            rsp_last      <= sel_hit ? sel_last : '0;
            rsp_stride    <= sel_hit ? sel_stride : '0;
            rsp_pred      <= sel_hit ? (sel_last + sel_stride) : '0;
            rsp_confident <= lk_valid && sel_hit && conf_trusted(sel_conf);
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R8
    confident_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_confident |-> (rsp_hit && rsp_valid));
    // R5
    alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_fix && !up_hit && lk_valid && (lk_pc == up_pc)
        |=> rsp_hit && (rsp_stride == '0) && !rsp_confident && (rsp_last == $past(up_value)));
    // R6
    train_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_fix && up_hit && lk_valid && (lk_pc == up_pc)
        |=> rsp_hit && (rsp_stride == $past(up_value - uc_last)));
    // R10
    repair_keeps_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_fix && up_hit && lk_valid && (lk_pc == up_pc)
        |=> rsp_hit && (rsp_stride == $past(uc_stride)) && (rsp_last == $past(up_value)));
endmodule

// File: tb/sim_stride_value_predictor.sv
// Self-checking bench with a behavioural reference model compared every clock.
module sim_stride_value_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 16, ALIGN_W = 2, IDX_W = 2, VAL_W = 16;
    localparam int NREC = 1 << IDX_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0, up_valid = 1'b0, up_fix = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
    logic [VAL_W-1:0] up_value = '0;
    logic rsp_valid, rsp_hit, rsp_confident;
    logic [VAL_W-1:0] rsp_last, rsp_stride, rsp_pred;

    int checks = 0, errors = 0;

    // reference records
    bit          m_valid [NREC];
    int          m_tag   [NREC];
    bit [15:0]   m_last  [NREC];
    bit [15:0]   m_stride[NREC];
    int          m_conf  [NREC];

    stride_value_predictor #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .VAL_W(VAL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .up_valid(up_valid), .up_pc(up_pc), .up_value(up_value), .up_fix(up_fix),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_last(rsp_last),
        .rsp_stride(rsp_stride), .rsp_pred(rsp_pred), .rsp_confident(rsp_confident));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int idx_of(logic [15:0] pc);
        return (int'(pc) >> ALIGN_W) % NREC;
    endfunction
    function automatic int tag_of(logic [15:0] pc);
        return int'(pc) >> (ALIGN_W + IDX_W);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREC; i++) begin
            m_valid[i] = 0; m_tag[i] = 0; m_last[i] = 0; m_stride[i] = 0; m_conf[i] = 0;
        end
    endtask

    // Apply one update to the reference model (R5, R6, R7, R10).
    task automatic model_update(logic [15:0] pc, logic [15:0] v, bit fix);
        int i = idx_of(pc);
        bit h = m_valid[i] && (m_tag[i] == tag_of(pc));
        bit [15:0] guess = m_last[i] + m_stride[i];
        if (fix) begin
            if (h) m_last[i] = v;
        end else if (h) begin
            if (v == guess) m_conf[i] = (m_conf[i] < 3) ? m_conf[i] + 1 : 3;
            else            m_conf[i] = (m_conf[i] > 0) ? m_conf[i] - 1 : 0;
            m_stride[i] = v - m_last[i];
            m_last[i]   = v;
        end else begin
            m_valid[i] = 1; m_tag[i] = tag_of(pc); m_last[i] = v; m_stride[i] = 0; m_conf[i] = 0;
        end
    endtask

    // One clock: drive at negedge, model the edge (update before lookup, R9), check after it.
    task automatic step(bit lk, logic [15:0] lpc, bit up, logic [15:0] upc,
                        logic [15:0] uv, bit fix, string req);
        int i;
        bit h;
        bit [15:0] el, es;
        @(negedge clk);
        lk_valid = lk; lk_pc = lpc; up_valid = up; up_pc = upc; up_value = uv; up_fix = fix;
        @(posedge clk);
        if (up) model_update(upc, uv, fix);
        i  = idx_of(lpc);
        h  = lk && m_valid[i] && (m_tag[i] == tag_of(lpc));
        el = h ? m_last[i] : 16'd0;
        es = h ? m_stride[i] : 16'd0;
        #1;
        chk(req, "valid (R2)", int'(rsp_valid), int'(lk));
        if (lk) begin
            chk(req, "hit (R3)", int'(rsp_hit), int'(h));
            chk(req, "last", int'(rsp_last), int'(el));
            chk(req, "stride", int'(rsp_stride), int'(es));
            chk(req, "pred (R4)", int'(rsp_pred), int'(16'(el + es)));
            chk(req, "confident (R8)", int'(rsp_confident), int'(h && m_conf[i] >= 2));
        end
    endtask

    task automatic look(logic [15:0] pc, string req);
        step(1, pc, 0, 16'h0, 16'h0, 0, req);
    endtask
    task automatic upd(logic [15:0] pc, logic [15:0] v, bit fix, string req);
        step(0, 16'h0, 1, pc, v, fix, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pa, pb, pool [6];
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "valid in reset", int'(rsp_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "valid after reset", int'(rsp_valid), 0);
        look(16'h0010, "R1");
        look(16'h0104, "R1");

        pa = 16'h0104;
        pb = pa + 16'(1 << (ALIGN_W + IDX_W)); // same index, different tag
        upd(pa, 16'd100, 0, "R5");
        look(pa, "R5");
        look(pa | 16'h3, "R3");               // alignment bits ignored
        upd(pa, 16'd110, 0, "R6");
        look(pa, "R6");
        upd(pa, 16'd120, 0, "R7");
        look(pa, "R7");
        upd(pa, 16'd130, 0, "R7");
        look(pa, "R8");
        upd(pa, 16'd140, 0, "R7");
        upd(pa, 16'd150, 0, "R7");
        look(pa, "R7");                       // saturated at 3
        upd(pa, 16'd999, 0, "R7");
        look(pa, "R8");                       // 3 -> 2 still trusted
        upd(pa, 16'd5, 0, "R7");
        look(pa, "R8");                       // 2 -> 1 untrusted
        upd(pa, 16'hFFF0, 0, "R4");
        look(pa, "R4");                       // wrap of stride and sum

        look(pb, "R3");                       // alias misses
        upd(pb, 16'd7, 0, "R5");
        look(pa, "R5");                       // displaced
        look(pb, "R5");

        step(1, pb, 1, pb, 16'd9, 0, "R9");   // same-cycle update seen
        step(1, pb, 1, pb, 16'd11, 0, "R9");
        step(1, pa, 1, pa, 16'd3, 0, "R9");   // allocation seen

        upd(pa, 16'd6, 0, "R6");
        upd(pa, 16'd9, 0, "R7");
        upd(pa, 16'd40, 1, "R10");            // repair on hit
        look(pa, "R10");
        upd(pb, 16'd77, 1, "R10");            // repair on miss: no change
        look(pb, "R10");
        look(pa, "R10");
        step(1, pa, 1, pa, 16'd50, 1, "R10");

        pool[0] = 16'h0100; pool[1] = 16'h0110; pool[2] = 16'h0204;
        pool[3] = 16'h0308; pool[4] = 16'h010C; pool[5] = 16'h041C;
        for (int k = 0; k < 400; k++) begin
            int a = $urandom_range(0, 5);
            int b = $urandom_range(0, 5);
            int mode = $urandom_range(0, 9);
            logic [15:0] v = (mode < 6) ? 16'(m_last[idx_of(pool[b])] + 16'd4) : 16'($urandom);
            step(($urandom_range(0, 3) != 0), pool[a], ($urandom_range(0, 2) != 0), pool[b],
                 v, (mode == 9), "R7");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule